// File: doc/BRIEF.md
# Triple Half-Bridge Control Core

This block is the digital control core of a driver for three half-bridges. It produces six registered gate-enable outputs: one low side and one high side per bridge. Stage `2k` is the low side of bridge `k` and stage `2k+1` is its high side.

A host configures the block through a 16-bit serial shift port with four signals: chip select, shift clock, data in and data out. Three kinds of digital protection flag feed the block, each with one flag per stage:

- thermal prewarning
- thermal shutdown
- overcurrent

A faulted stage is latched off until software clears it. A common PWM pin gates every stage that software has selected for PWM.

The serial signals are sampled by the system clock. The host must hold each level of `cs_n` and `sclk` for at least two clock cycles. The serial port has no back-pressure: the host paces every transfer with `sclk`, and the block accepts one write word per completed transfer.

Each transfer shifts a status snapshot out and shifts a command word in.

**Command word (host to block):**

| Bits | Meaning |
|------|---------|
| 15 | Fault clear. Acts as a pulse and is not stored. |
| 14 | Overcurrent cut-off enable. |
| 13 | Run. When 0, the block is inhibited. |
| 12 | Ignored. |
| 11:6 | PWM select, one bit per stage. |
| 5:0 | Stage enable, one bit per stage. |

**Status snapshot (block to host):**

| Bits | Meaning |
|------|---------|
| 15 | Temperature warning. |
| 14 | Overload. |
| 13:6 | Zero. |
| 5:0 | Stage status. A stage's bit is 1 when the stage is enabled, the block is running, and the stage is not latched off. |

Top module: `hbd_ctrl`

## Requirements
- R1: Data in is sampled on each rising `sclk` while `cs_n` is low, MSB first. The command word takes effect at the first clock after `cs_n` rises, and only if exactly 16 rising `sclk` edges occurred. Transfers with fewer or more edges change neither the configuration nor the status.
- R2: `sdo` is 0 while `cs_n` is high. During a transfer it presents the snapshot taken when `cs_n` fell, MSB first. Bit 14 of the snapshot appears after the first rising `sclk`, and so on down the word.
- R3: Bit 15 of the snapshot (temperature warning) is the OR of all prewarning flags, registered once. While no `sclk` edge has been seen, `sdo` shows this bit combinationally from the moment `cs_n` falls.
- R4: A thermal shutdown flag on a stage latches that stage off. Its status bit reads 0, the overload bit reads 1, and its output is low two clocks after the flag is sampled.
- R5: A stage latched off by thermal shutdown stays off while its flag is still high, even if a fault clear is written. It also stays off after the flag drops, until a fault clear is written.
- R6: With overcurrent cut-off enabled, an overcurrent flag held for `OC_FILT` consecutive clocks (default 8) latches the stage off and sets overload. A flag held for fewer clocks has no effect.
- R7: With overcurrent cut-off disabled, overcurrent flags neither turn any stage off nor set overload.
- R8: Writing the fault clear bit clears overload and releases every latched stage whose thermal flag is low. A fault arriving in the same cycle wins.
- R9: While the run bit is 0, all outputs are low and all status bits read 0, but transfers still work. Writing the run bit as 1 restores the outputs.
- R10: A running, enabled, unlatched stage follows the PWM pin when its PWM select bit is 1. Otherwise it is held high.
- R11: The two stages of one bridge are never high together. If both would be on, both outputs are driven low.
- R12: After reset, all outputs are low, `sdo` is low, and the status snapshot is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| pwm | input | 1 | Common PWM gate |
| prewarn | input | 6 | Per-stage thermal prewarning flags |
| tshut | input | 6 | Per-stage thermal shutdown flags |
| ocur | input | 6 | Per-stage overcurrent flags |
| drv | output | 6 | Registered stage enables, bit `2k` low side and bit `2k+1` high side |

## Verification
The assertions check on every cycle that:
- no bridge has both stages high (R11);
- a stage with a thermal shutdown flag is low two clocks later (R4);
- the run bit being low forces all outputs low (R9);
- `sdo` is idle whenever `cs_n` is high (R2);
- overload falls only after a fault clear (R8) and never rises from overcurrent while cut-off is disabled (R7).

Only the bench scenarios can show the rest:
- the serial framing and the rejection of short and long transfers (R1);
- the exact readback word and the immediate warning bit (R3);
- the filter length of the overcurrent delay (R6);
- the ordering of flag release against fault clear (R5);
- the PWM gating across all enable and select patterns (R10).

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int NBR   = 3;
  localparam int NST   = 2 * NBR;
  localparam int WORD  = 16;
  localparam int CNT_W = $clog2(WORD + 2);
  // command word fields
  localparam int B_CLR = 15;
  localparam int B_OCE = 14;
  localparam int B_RUN = 13;
  localparam int B_SPARE = 12;
  // snapshot fields
  localparam int B_TMP = 15;
  localparam int B_OVL = 14;

  typedef struct packed {
    logic [NST-1:0] sel;
    logic [NST-1:0] en;
    logic           run;
    logic           oce;
  } cfg_t;
endpackage

// File: rtl/hbd_serial.sv
module hbd_serial
  import hbd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            sdi,
  input  logic [WORD-1:0] snap,
  input  logic            tmp_now,
  output logic            sdo,
  output logic            wr_stb,
  output logic [WORD-1:0] wr_word
);
  logic            cs_q, sclk_q;
  logic [CNT_W-1:0] cnt;
  logic [WORD-1:0] sh_in, sh_out;
  logic            cs_fall, cs_rise, sck_rise;

  assign cs_fall  = cs_q & ~cs_n;
  assign cs_rise  = ~cs_q & cs_n;
  assign sck_rise = ~sclk_q & sclk & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      cnt    <= '0;
      sh_in  <= '0;
      sh_out <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_n) begin
        cnt <= '0;
      end else if (cs_fall) begin
        cnt    <= '0;
        sh_out <= snap;
      end else if (sck_rise) begin
        if (cnt != CNT_W'(WORD + 1)) cnt <= cnt + 1'b1;
        sh_in  <= {sh_in[WORD-2:0], sdi};
        sh_out <= {sh_out[WORD-2:0], 1'b0};
      end
    end
  end

  assign wr_stb  = cs_rise && (cnt == CNT_W'(WORD));
  assign wr_word = sh_in;
  assign sdo     = cs_n ? 1'b0 : ((cnt == '0) ? tmp_now : sh_out[WORD-1]);
endmodule

// File: rtl/hbd_protect.sv
module hbd_protect
  import hbd_pkg::*;
#(
  parameter int OC_FILT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           oce,
  input  logic           clr,
  input  logic [NST-1:0] tshut,
  input  logic [NST-1:0] ocur,
  output logic [NST-1:0] off_lat,
  output logic           ovl
);
  localparam int FW = $clog2(OC_FILT + 1);
  logic [NST-1:0] hit;

  for (genvar g = 0; g < NST; g++) begin : g_stage
    logic [FW-1:0] fc;
    logic          lat;
    logic          trip;

    assign trip   = ocur[g] & oce & (fc == FW'(OC_FILT - 1));
    assign hit[g] = tshut[g] | trip;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fc  <= '0;
        lat <= 1'b0;
      end else begin
        if (!(ocur[g] & oce)) fc <= '0;
        else if (fc != FW'(OC_FILT)) fc <= fc + 1'b1;
        lat <= hit[g] | (lat & ~(clr & ~tshut[g]));
      end
    end
    assign off_lat[g] = lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovl <= 1'b0;
    else        ovl <= (|hit) | (ovl & ~clr);
  end
endmodule

// File: rtl/hbd_outstage.sv
module hbd_outstage
  import hbd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NST-1:0] req,
  output logic [NST-1:0] drv
);
  for (genvar b = 0; b < NBR; b++) begin : g_bridge
    logic [1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q <= 2'b00;
      else if (&req[2*b +: 2])    q <= 2'b00;
      else                        q <= req[2*b +: 2];
    end
    assign drv[2*b +: 2] = q;
  end
endmodule

// File: rtl/hbd_ctrl.sv
module hbd_ctrl
  import hbd_pkg::*;
#(
  parameter int OC_FILT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           sdi,
  output logic           sdo,
  input  logic           pwm,
  input  logic [NST-1:0] prewarn,
  input  logic [NST-1:0] tshut,
  input  logic [NST-1:0] ocur,
  output logic [NST-1:0] drv
);
  cfg_t            cfg;
  logic            tmp_q;
  logic            ovl_q;
  logic            wr_stb;
  logic [WORD-1:0] wr_word;
  logic [WORD-1:0] snap;
  logic [NST-1:0]  off_lat, status, req;
  logic            clr_hit;
  logic            unused_spare;

  assign clr_hit      = wr_stb & wr_word[B_CLR];
  assign unused_spare = wr_word[B_SPARE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      tmp_q <= 1'b0;
    end else begin
      tmp_q <= |prewarn;
      if (wr_stb) begin
        cfg.en  <= wr_word[NST-1:0];
        cfg.sel <= wr_word[2*NST-1:NST];
        cfg.run <= wr_word[B_RUN];
        cfg.oce <= wr_word[B_OCE];
      end
    end
  end

  assign status = cfg.en & {NST{cfg.run}} & ~off_lat;
  assign req    = status & (~cfg.sel | {NST{pwm}});
  always_comb begin
    snap          = '0;
    snap[B_TMP]   = tmp_q;
    snap[B_OVL]   = ovl_q;
    snap[NST-1:0] = status;
  end

  hbd_serial u_ser (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .snap(snap), .tmp_now(tmp_q), .sdo(sdo), .wr_stb(wr_stb), .wr_word(wr_word)
  );

  hbd_protect #(.OC_FILT(OC_FILT)) u_prot (
    .clk(clk), .rst_n(rst_n), .oce(cfg.oce), .clr(clr_hit),
    .tshut(tshut), .ocur(ocur), .off_lat(off_lat), .ovl(ovl_q)
  );

  hbd_outstage u_out (
    .clk(clk), .rst_n(rst_n), .req(req), .drv(drv)
  );
endmodule

// File: rtl/hbd_ctrl_chk.sv
module hbd_ctrl_chk
  import hbd_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           sdo,
  input logic [NST-1:0] tshut,
  input logic [NST-1:0] drv,
  input logic           run,
  input logic           oce,
  input logic           ovl,
  input logic           clr
);
  logic [NST-1:0] ts_d1, ts_d2;
  logic           pair_clash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_d1 <= '0;
      ts_d2 <= '0;
    end else begin
      ts_d1 <= tshut;
      ts_d2 <= ts_d1;
    end
  end

  always_comb begin
    pair_clash = 1'b0;
    for (int b = 0; b < NBR; b++) pair_clash = pair_clash | (drv[2*b] & drv[2*b+1]);
  end

  AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n) !pair_clash); // R11
  AST_THERMAL_OFF:   assert property (@(posedge clk) disable iff (!rst_n) (drv & ts_d2) == '0); // R4
  AST_INHIBIT_OFF:   assert property (@(posedge clk) disable iff (!rst_n) !run |=> drv == '0); // R9
  AST_SDO_IDLE:      assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sdo); // R2
  AST_OVL_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) $fell(ovl) |-> $past(clr)); // R8
  AST_OCS_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) (!oce && tshut == '0 && !ovl) |=> !ovl); // R7
endmodule

bind hbd_ctrl hbd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .tshut(tshut), .drv(drv),
  .run(cfg.run), .oce(cfg.oce), .ovl(ovl_q), .clr(clr_hit)
);

// File: tb/hbd_ctrl_test.sv
module hbd_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, pwm = 1'b0;
  logic       sdo;
  logic [5:0] prewarn = '0, tshut = '0, ocur = '0;
  logic [5:0] drv;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;
  logic [15:0] rd;

  always #10 clk = ~clk;

  hbd_ctrl #(.OC_FILT(8)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .pwm(pwm), .prewarn(prewarn), .tshut(tshut), .ocur(ocur), .drv(drv)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cmd(input logic clr, input logic oce, input logic run,
                                      input logic [5:0] sel, input logic [5:0] en);
    return {clr, oce, run, 1'b0, sel, en};
  endfunction

  function automatic logic [15:0] stw(input logic tmp, input logic ovl, input logic [5:0] st);
    return {tmp, ovl, 8'h00, st};
  endfunction

  function automatic logic [5:0] exp_drv(input logic [5:0] en, input logic [5:0] sel,
                                         input logic run, input logic [5:0] lat, input logic p);
    logic [5:0] r;
    r = en & ~lat & {6{run}} & (~sel | {6{p}});
    for (int b = 0; b < 3; b++) if (r[2*b] && r[2*b+1]) begin r[2*b] = 1'b0; r[2*b+1] = 1'b0; end
    return r;
  endfunction

  task automatic xfer(input logic [15:0] w, input int nb, output logic [15:0] r);
    r = '0;
    cs_n = 1'b0;
    tick(1);
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      tick(1);
      if (i < 16) r[15-i] = sdo;
      sclk = 1'b1;
      tick(2);
      sclk = 1'b0;
      tick(1);
    end
    cs_n = 1'b1;
    sdi  = 1'b0;
    tick(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] prev;
    logic [5:0] selv;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R12 reset state
    chk(drv == 6'h00, "R12 drv after reset", {10'h0, drv}, 16'h0);
    chk(sdo == 1'b0, "R12 sdo idle", {15'h0, sdo}, 16'h0);
    xfer(16'h0000, 16, rd);
    chk(rd == 16'h0000, "R12 snapshot after reset", rd, 16'h0);

    // R1 R2 R10 R11 sweep over enables, selects and PWM level
    prev = '0;
    for (int sp = 0; sp < 3; sp++) begin
      selv = (sp == 0) ? 6'h00 : ((sp == 1) ? 6'h3F : 6'h15);
      for (int e = 0; e < 64; e++) begin
        xfer(cmd(1'b0, 1'b0, 1'b1, selv, 6'(e)), 16, rd);
        chk(rd == stw(1'b0, 1'b0, prev), "R2 readback of previous status", rd, stw(1'b0, 1'b0, prev));
        for (int p = 0; p < 2; p++) begin
          pwm = p[0];
          tick(2);
          chk(drv == exp_drv(6'(e), selv, 1'b1, 6'h00, p[0]), "R10 R11 R1 gated drive",
              {10'h0, drv}, {10'h0, exp_drv(6'(e), selv, 1'b1, 6'h00, p[0])});
        end
        pwm  = 1'b0;
        prev = 6'(e);
      end
    end

    // R1 aborted transfers
    xfer(cmd(1'b0, 1'b0, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(drv == 6'h2A, "R1 full write", {10'h0, drv}, 16'h002A);
    xfer(cmd(1'b0, 1'b0, 1'b1, 6'h00, 6'h15), 10, rd);
    chk(drv == 6'h2A, "R1 short transfer ignored", {10'h0, drv}, 16'h002A);
    xfer(cmd(1'b0, 1'b0, 1'b1, 6'h00, 6'h15), 17, rd);
    chk(drv == 6'h2A, "R1 long transfer ignored", {10'h0, drv}, 16'h002A);
    xfer(cmd(1'b0, 1'b0, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(rd == stw(1'b0, 1'b0, 6'h2A), "R1 status unchanged by aborts", rd, stw(1'b0, 1'b0, 6'h2A));

    // R3 warning bit visible at chip select fall
    prewarn = 6'b000100;
    tick(2);
    cs_n = 1'b0;
    #1;
    chk(sdo == 1'b1, "R3 warning at cs fall", {15'h0, sdo}, 16'h1);
    tick(1);
    cs_n = 1'b1;
    tick(2);
    xfer(cmd(1'b0, 1'b0, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(rd == stw(1'b1, 1'b0, 6'h2A), "R3 warning in snapshot", rd, stw(1'b1, 1'b0, 6'h2A));
    prewarn = 6'h00;
    tick(2);
    cs_n = 1'b0;
    #1;
    chk(sdo == 1'b0, "R3 warning cleared", {15'h0, sdo}, 16'h0);
    tick(1);
    cs_n = 1'b1;
    tick(2);
    chk(drv == 6'h2A, "R1 chip select pulse without clocks ignored", {10'h0, drv}, 16'h002A);

    // R4 R5 R8 thermal shutdown
    tshut = 6'b000010;
    tick(3);
    chk(drv == 6'h28, "R4 thermal stage off", {10'h0, drv}, 16'h0028);
    xfer(cmd(1'b0, 1'b0, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(rd == stw(1'b0, 1'b1, 6'h28), "R4 overload and status", rd, stw(1'b0, 1'b1, 6'h28));
    xfer(cmd(1'b1, 1'b0, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(drv == 6'h28, "R5 clear ignored while flag high", {10'h0, drv}, 16'h0028);
    xfer(cmd(1'b0, 1'b0, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(rd == stw(1'b0, 1'b1, 6'h28), "R5 overload kept while flag high", rd, stw(1'b0, 1'b1, 6'h28));
    tshut = 6'h00;
    tick(4);
    chk(drv == 6'h28, "R5 stays off after flag drops", {10'h0, drv}, 16'h0028);
    xfer(cmd(1'b1, 1'b0, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(drv == 6'h2A, "R8 clear restores stage", {10'h0, drv}, 16'h002A);
    xfer(cmd(1'b0, 1'b0, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(rd == stw(1'b0, 1'b0, 6'h2A), "R8 overload cleared", rd, stw(1'b0, 1'b0, 6'h2A));

    // R6 overcurrent filter
    xfer(cmd(1'b0, 1'b1, 1'b1, 6'h00, 6'h2A), 16, rd);
    ocur = 6'b001000;
    tick(7);
    ocur = 6'h00;
    tick(3);
    chk(drv == 6'h2A, "R6 short overcurrent filtered", {10'h0, drv}, 16'h002A);
    ocur = 6'b001000;
    tick(8);
    ocur = 6'h00;
    tick(3);
    chk(drv == 6'h22, "R6 overcurrent trip", {10'h0, drv}, 16'h0022);
    xfer(cmd(1'b0, 1'b1, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(rd == stw(1'b0, 1'b1, 6'h22), "R6 overload and status", rd, stw(1'b0, 1'b1, 6'h22));
    xfer(cmd(1'b1, 1'b1, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(drv == 6'h2A, "R8 clear after overcurrent", {10'h0, drv}, 16'h002A);

    // R7 overcurrent ignored when cut-off disabled
    xfer(cmd(1'b0, 1'b0, 1'b1, 6'h00, 6'h2A), 16, rd);
    ocur = 6'h3F;
    tick(30);
    chk(drv == 6'h2A, "R7 no cut-off", {10'h0, drv}, 16'h002A);
    ocur = 6'h00;
    tick(2);
    xfer(cmd(1'b0, 1'b0, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(rd == stw(1'b0, 1'b0, 6'h2A), "R7 overload stays clear", rd, stw(1'b0, 1'b0, 6'h2A));

    // R9 inhibit
    xfer(cmd(1'b0, 1'b0, 1'b0, 6'h00, 6'h2A), 16, rd);
    chk(drv == 6'h00, "R9 inhibit forces off", {10'h0, drv}, 16'h0);
    xfer(cmd(1'b0, 1'b0, 1'b0, 6'h00, 6'h2A), 16, rd);
    chk(rd == stw(1'b0, 1'b0, 6'h00), "R9 serial active while inhibited", rd, stw(1'b0, 1'b0, 6'h00));
    xfer(cmd(1'b0, 1'b0, 1'b1, 6'h00, 6'h2A), 16, rd);
    chk(drv == 6'h2A, "R9 run restores outputs", {10'h0, drv}, 16'h002A);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule